// File: doc/BRIEF.md
# SD Host Single-Address DMA Engine

This block moves data blocks between system memory and the card data path of an SD host controller using the simple single-address DMA mode. Software programs a starting system address, a block length with an address-boundary code, a block count and a transfer mode. It then launches the transfer by writing the transfer mode with DMA enabled. In one direction the engine fetches words from memory and streams them to the card side. In the other it accepts words from the card side and stores them to memory. The address advances by one word per move.

Whenever the running address reaches a multiple of the programmed boundary and data remains, the engine stops and raises a DMA-boundary status bit. It waits until software rewrites the system address, then continues from the new address. When the last block has been moved it raises a transfer-complete status bit instead. Status bits are cleared by writing ones. Only the simple DMA select code is served. Any other select code leaves the engine idle.

Top module: `sdma_engine`

## Requirements
- R1: After reset, every register reads zero, no memory request is made, and the card side is neither offered nor asked for data.
- R2: A write to transfer mode (register 3) with bit 0 set, made while idle, starts a transfer only when host control (register 4) bits [4:3] are 00. Any other select value leaves memory untouched and status at zero.
- R3: Transfer mode bit 4 = 1 moves card words to memory at consecutive addresses. Bit 4 = 0 reads memory words in address order and offers them on the card transmit stream. A block is the byte length in block size (register 1) bits [11:0], rounded up to whole 4-byte words.
- R4: The address advances by 4 after every moved word. Reading the system address (register 0) returns the address of the next word.
- R5: With transfer mode bit 5 clear, exactly one block is moved, whatever the block count.
- R6: With bits 5 and 1 both set, the number of blocks in block count (register 2) is moved. With bit 1 set, the count drops by one after each block and reads back the remaining blocks.
- R7: A start with bits 5 and 1 set and a block count of zero moves nothing and sets transfer complete.
- R8: The boundary is 4 KiB shifted left by block size bits [14:12]. When a moved word leaves the address on a boundary and data remains, status (register 5) bit 3 is set and no further data moves.
- R9: A system-address write while paused resumes the transfer from the written address. A system-address write while moving data is ignored.
- R10: Status bit 1 is set when the final word is moved. If that word also ends on a boundary, only bit 1 is set.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R12: A transfer-mode write with bit 0 clear while busy stops the transfer at once, without setting any status bit.
- R13: While busy, writes to block size, block count and host control are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select (0 address, 1 block size, 2 count, 3 mode, 4 host control, 5 status) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| mem_req_o | output | 1 | Memory request, held until granted |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| card_tx_valid_o | output | 1 | Word offered to the card side |
| card_tx_data_o | output | 32 | Word to the card side |
| card_tx_ready_i | input | 1 | Card side takes the offered word |
| card_rx_valid_i | input | 1 | Word available from the card side |
| card_rx_data_i | input | 32 | Word from the card side |
| card_rx_ready_o | output | 1 | Engine takes the card word |

## Verification
The final word of a transfer and a boundary crossing can be decided in the same cycle. The rule is that completion wins and no boundary status appears. The bench provokes this with a one-block transfer whose last word ends exactly on a 4 KiB line. It expects status to read only the complete bit and the address to sit on the line. A second case starts two words below the boundary, so the pause falls mid-block. That case must show only the boundary bit until the address rewrite has let the block finish.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [2:0] {
    REG_SYSADDR = 3'd0,
    REG_BLKSIZE = 3'd1,
    REG_BLKCNT  = 3'd2,
    REG_TMODE   = 3'd3,
    REG_HOSTCTL = 3'd4,
    REG_STATUS  = 3'd5
  } reg_sel_e;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_FETCH,
    XS_FWAIT,
    XS_PUSH,
    XS_PULL,
    XS_STORE,
    XS_PAUSE
  } xfer_state_e;

  localparam int TM_EN    = 0;
  localparam int TM_CNTEN = 1;
  localparam int TM_RD    = 4;
  localparam int TM_MULTI = 5;
  localparam int ST_CMP   = 1;
  localparam int ST_BND   = 3;
endpackage

// File: rtl/sdma_addr.sv
module sdma_addr #(
  parameter int AW            = 32,
  parameter int STEP          = 4,
  parameter int BND_BASE_LOG2 = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic [2:0]    bnd_code_i,
  output logic [AW-1:0] addr_o,
  output logic          bnd_hit_o
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] INC = AW'(STEP);

  logic [AW-1:0] addr_q, addr_nxt, bnd_mask;

  assign addr_nxt  = addr_q + INC;
  assign bnd_mask  = (ONE << (BND_BASE_LOG2 + int'(bnd_code_i))) - ONE;
  // the word moved now leaves the address on a boundary
  assign bnd_hit_o = (addr_nxt & bnd_mask) == '0;
  assign addr_o    = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= load_val_i;
    else if (step_i)  addr_q <= addr_nxt;
  end

  a_r4_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> addr_q == $past(addr_q) + INC);
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int BLEN_W = 12,
  parameter int BCNT_W = 16,
  parameter int WCNT_W = BLEN_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [AW-1:0]     cur_addr_i,
  input  logic              busy_i,
  input  logic              paused_i,
  input  logic              blk_done_i,
  input  logic              cmp_set_i,
  input  logic              dma_set_i,
  output logic              start_o,
  output logic              abort_o,
  output logic              load_o,
  output logic              resume_o,
  output logic              dir_rd_o,
  output logic              last_blk_o,
  output logic              zero_blk_o,
  output logic [2:0]        bnd_code_o,
  output logic [WCNT_W-1:0] words_o
);
  localparam int BS_W = BLEN_W + 3;

  logic [BS_W-1:0]   blksize_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [5:0]        tmode_q;
  logic [7:0]        hostctl_q;
  logic [15:0]       status_q;
  logic              start_q;
  logic              cfg_lock;
  logic              wr_sys, wr_bs, wr_bc, wr_tm, wr_hc, wr_st;
  logic              start_d;

  assign cfg_lock = busy_i || start_q;
  assign wr_sys = we_i && (addr_i == REG_SYSADDR);
  assign wr_bs  = we_i && (addr_i == REG_BLKSIZE);
  assign wr_bc  = we_i && (addr_i == REG_BLKCNT);
  assign wr_tm  = we_i && (addr_i == REG_TMODE);
  assign wr_hc  = we_i && (addr_i == REG_HOSTCTL);
  assign wr_st  = we_i && (addr_i == REG_STATUS);

  assign start_d  = wr_tm && wdata_i[TM_EN] && !cfg_lock && (hostctl_q[4:3] == 2'b00);
  assign abort_o  = wr_tm && !wdata_i[TM_EN] && busy_i;
  assign load_o   = wr_sys && !start_q && (!busy_i || paused_i);
  assign resume_o = load_o && paused_i;
  assign start_o  = start_q;

  assign dir_rd_o   = tmode_q[TM_RD];
  assign last_blk_o = !tmode_q[TM_MULTI] || (tmode_q[TM_CNTEN] && bcnt_q == BCNT_W'(1));
  assign zero_blk_o = tmode_q[TM_MULTI] && tmode_q[TM_CNTEN] && bcnt_q == '0;
  assign bnd_code_o = blksize_q[BS_W-1:BLEN_W];
  assign words_o    = WCNT_W'(blksize_q[BLEN_W-1:2]) + WCNT_W'(|blksize_q[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blksize_q <= '0;
      bcnt_q    <= '0;
      tmode_q   <= '0;
      hostctl_q <= '0;
      status_q  <= '0;
      start_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      if (wr_bs && !cfg_lock) blksize_q <= wdata_i[BS_W-1:0];
      if (wr_hc && !cfg_lock) hostctl_q <= wdata_i[7:0];
      if (wr_tm && (!cfg_lock || abort_o))
        tmode_q <= {wdata_i[5:4], 2'b00, wdata_i[1:0]};
      if (wr_bc && !cfg_lock)
        bcnt_q <= wdata_i[BCNT_W-1:0];
      else if (blk_done_i && tmode_q[TM_CNTEN] && bcnt_q != '0)
        bcnt_q <= bcnt_q - BCNT_W'(1);
      begin
        logic [15:0] st;
        st = status_q;
        if (wr_st) st = st & ~wdata_i[15:0];
        if (cmp_set_i) st[ST_CMP] = 1'b1;
        if (dma_set_i) st[ST_BND] = 1'b1;
        status_q <= st;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_SYSADDR: rdata_o = 32'(cur_addr_i);
      REG_BLKSIZE: rdata_o = 32'(blksize_q);
      REG_BLKCNT:  rdata_o = 32'(bcnt_q);
      REG_TMODE:   rdata_o = 32'(tmode_q);
      REG_HOSTCTL: rdata_o = 32'(hostctl_q);
      REG_STATUS:  rdata_o = 32'(status_q);
      default:     rdata_o = '0;
    endcase
  end

  a_r6_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done_i && tmode_q[TM_CNTEN] && bcnt_q != '0 |=> bcnt_q == $past(bcnt_q) - BCNT_W'(1));
  a_r11_w1c_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_st && wdata_i[ST_CMP] && !cmp_set_i |=> !status_q[ST_CMP]);
  a_r11_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_st && !wdata_i[ST_BND] && status_q[ST_BND] |=> status_q[ST_BND]);
  a_r13_size_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && wr_bs |=> $stable(blksize_q));
endmodule

// File: rtl/sdma_xfer.sv
module sdma_xfer
  import sdma_pkg::*;
#(
  parameter int DW     = 32,
  parameter int WCNT_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              resume_i,
  input  logic              dir_rd_i,
  input  logic              last_blk_i,
  input  logic              zero_blk_i,
  input  logic              bnd_hit_i,
  input  logic [WCNT_W-1:0] words_i,
  output logic              busy_o,
  output logic              paused_o,
  output logic              step_o,
  output logic              blk_done_o,
  output logic              cmp_set_o,
  output logic              dma_set_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              card_tx_valid_o,
  output logic [DW-1:0]     card_tx_data_o,
  input  logic              card_tx_ready_i,
  input  logic              card_rx_valid_i,
  input  logic [DW-1:0]     card_rx_data_i,
  output logic              card_rx_ready_o
);
  xfer_state_e       state_q, state_d, first_st;
  logic [WCNT_W-1:0] wcnt_q;
  logic [DW-1:0]     data_q;
  logic              last_word;

  assign first_st  = dir_rd_i ? XS_PULL : XS_FETCH;
  assign last_word = wcnt_q == words_i - WCNT_W'(1);
  assign busy_o    = state_q != XS_IDLE;
  assign paused_o  = state_q == XS_PAUSE;

  assign mem_req_o       = (state_q == XS_FETCH) || (state_q == XS_STORE);
  assign mem_we_o        = state_q == XS_STORE;
  assign mem_wdata_o     = data_q;
  assign card_tx_valid_o = state_q == XS_PUSH;
  assign card_tx_data_o  = data_q;
  assign card_rx_ready_o = state_q == XS_PULL;

  assign step_o = ((state_q == XS_PUSH) && card_tx_ready_i) ||
                  ((state_q == XS_STORE) && mem_gnt_i);
  assign blk_done_o = step_o && last_word;

  always_comb begin
    state_d   = state_q;
    cmp_set_o = 1'b0;
    dma_set_o = 1'b0;
    unique case (state_q)
      XS_IDLE:  if (start_i) begin
                  if (zero_blk_i) cmp_set_o = 1'b1;
                  else            state_d = first_st;
                end
      XS_FETCH: if (mem_gnt_i) state_d = XS_FWAIT;
      XS_FWAIT: if (mem_rvalid_i) state_d = XS_PUSH;
      XS_PULL:  if (card_rx_valid_i) state_d = XS_STORE;
      XS_PAUSE: if (resume_i) state_d = first_st;
      default:  ;
    endcase
    if (step_o) begin
      if (last_word && last_blk_i) begin
        cmp_set_o = 1'b1;
        state_d   = XS_IDLE;
      end else if (bnd_hit_i) begin
        dma_set_o = 1'b1;
        state_d   = XS_PAUSE;
      end else begin
        state_d = first_st;
      end
    end
    if (abort_i) begin
      state_d   = XS_IDLE;
      cmp_set_o = 1'b0;
      dma_set_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      wcnt_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (abort_i || (state_q == XS_IDLE)) wcnt_q <= '0;
      else if (step_o) wcnt_q <= last_word ? '0 : wcnt_q + WCNT_W'(1);
      if ((state_q == XS_FWAIT) && mem_rvalid_i) data_q <= mem_rdata_i;
      if ((state_q == XS_PULL) && card_rx_valid_i) data_q <= card_rx_data_i;
    end
  end

  a_r10_cmp_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmp_set_o && dma_set_o));
  a_r8_pause_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> !mem_req_o && !card_rx_ready_o && !card_tx_valid_o);
  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i && !abort_i |=> mem_req_o);
  a_r12_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_o);
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine #(
  parameter int AW            = 32,
  parameter int DW            = 32,
  parameter int BLEN_W        = 12,
  parameter int BCNT_W        = 16,
  parameter int BND_BASE_LOG2 = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          card_tx_valid_o,
  output logic [DW-1:0] card_tx_data_o,
  input  logic          card_tx_ready_i,
  input  logic          card_rx_valid_i,
  input  logic [DW-1:0] card_rx_data_i,
  output logic          card_rx_ready_o
);
  localparam int WCNT_W = BLEN_W - 1;
  localparam int STEP   = DW / 8;

  logic              busy, paused, step, blk_done, cmp_set, dma_set;
  logic              start, abort, load, resume, dir_rd, last_blk, zero_blk, bnd_hit;
  logic [2:0]        bnd_code;
  logic [WCNT_W-1:0] words;
  logic [AW-1:0]     cur_addr;

  assign mem_addr_o = cur_addr;

  sdma_regs #(.AW(AW), .BLEN_W(BLEN_W), .BCNT_W(BCNT_W), .WCNT_W(WCNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .cur_addr_i(cur_addr), .busy_i(busy), .paused_i(paused),
    .blk_done_i(blk_done), .cmp_set_i(cmp_set), .dma_set_i(dma_set),
    .start_o(start), .abort_o(abort), .load_o(load), .resume_o(resume),
    .dir_rd_o(dir_rd), .last_blk_o(last_blk), .zero_blk_o(zero_blk),
    .bnd_code_o(bnd_code), .words_o(words)
  );

  sdma_addr #(.AW(AW), .STEP(STEP), .BND_BASE_LOG2(BND_BASE_LOG2)) u_addr (
    .clk_i, .rst_ni,
    .load_i(load), .load_val_i(reg_wdata_i[AW-1:0]), .step_i(step),
    .bnd_code_i(bnd_code), .addr_o(cur_addr), .bnd_hit_o(bnd_hit)
  );

  sdma_xfer #(.DW(DW), .WCNT_W(WCNT_W)) u_xfer (
    .clk_i, .rst_ni,
    .start_i(start), .abort_i(abort), .resume_i(resume), .dir_rd_i(dir_rd),
    .last_blk_i(last_blk), .zero_blk_i(zero_blk), .bnd_hit_i(bnd_hit), .words_i(words),
    .busy_o(busy), .paused_o(paused), .step_o(step), .blk_done_o(blk_done),
    .cmp_set_o(cmp_set), .dma_set_o(dma_set),
    .mem_req_o, .mem_we_o, .mem_wdata_o, .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .card_tx_valid_o, .card_tx_data_o, .card_tx_ready_i,
    .card_rx_valid_i, .card_rx_data_i, .card_rx_ready_o
  );
endmodule

// File: tb/sdma_engine_test.sv
module sdma_engine_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        tx_valid, rx_ready;
  logic [31:0] tx_data, rx_data;
  logic        stall = 1'b0;
  logic [31:0] mem [0:4095];
  logic [31:0] tx_log [0:63];
  int          tx_n = 0, rx_idx = 0;
  int          checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdma_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .card_tx_valid_o(tx_valid), .card_tx_data_o(tx_data), .card_tx_ready_i(1'b1),
    .card_rx_valid_i(1'b1), .card_rx_data_i(rx_data), .card_rx_ready_o(rx_ready)
  );

  assign mem_gnt = mem_req && !stall;
  assign rx_data = 32'hA000_0000 + 32'(rx_idx);

  always @(posedge clk) begin
    if (!rst_n) begin
      stall <= 1'b0; mem_rvalid <= 1'b0; tx_n <= 0; rx_idx <= 0;
    end else begin
      stall      <= ~stall;
      mem_rvalid <= mem_gnt && !mem_we;
      mem_rdata  <= mem[mem_addr[13:2]];
      if (mem_gnt && mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      if (tx_valid) begin tx_log[tx_n[5:0]] <= tx_data; tx_n <= tx_n + 1; end
      if (rx_ready) rx_idx <= rx_idx + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic wait_status(output logic [31:0] s);
    s = '0;
    for (int i = 0; i < 3000 && s == '0; i++) rd(3'd5, s);
  endtask

  task automatic t_reset();
    chk_reg(3'd0, 32'h0, "R1 address");
    chk_reg(3'd1, 32'h0, "R1 block size");
    chk_reg(3'd2, 32'h0, "R1 count");
    chk_reg(3'd5, 32'h0, "R1 status");
    chk(!mem_req && !tx_valid && !rx_ready, "R1 quiet ports", {29'b0, mem_req, tx_valid, rx_ready}, 32'h0);
  endtask

  // single block to memory, count ignored beyond one block
  task automatic t_single_read();
    logic [31:0] s; int b;
    b = rx_idx;
    wr(3'd0, 32'h100); wr(3'd1, 32'h7010); wr(3'd2, 32'd5); wr(3'd3, 32'h13);
    wait_status(s);
    chk(s == 32'h2, "R10 complete", s, 32'h2);
    for (int k = 0; k < 4; k++)
      chk(mem[12'h40 + k] == 32'hA000_0000 + 32'(b + k), "R3 card to memory", mem[12'h40 + k], 32'hA000_0000 + 32'(b + k));
    chk_reg(3'd0, 32'h110, "R4 next address");
    chk_reg(3'd2, 32'd4, "R5 one block only");
    wr(3'd5, 32'h0);
    chk_reg(3'd5, 32'h2, "R11 zero write keeps");
    wr(3'd5, 32'h2);
    chk_reg(3'd5, 32'h0, "R11 one clears");
  endtask

  task automatic t_multi_write();
    logic [31:0] s; int t0;
    for (int k = 0; k < 6; k++) mem[12'h100 + k] = 32'h5500 + 32'(k);
    t0 = tx_n;
    wr(3'd0, 32'h400); wr(3'd1, 32'h7008); wr(3'd2, 32'd3); wr(3'd3, 32'h23);
    wait_status(s);
    chk(s == 32'h2, "R10 complete", s, 32'h2);
    chk(tx_n - t0 == 6, "R6 three blocks of two words", 32'(tx_n - t0), 32'd6);
    for (int k = 0; k < 6; k++)
      chk(tx_log[6'(t0 + k)] == 32'h5500 + 32'(k), "R3 memory to card", tx_log[6'(t0 + k)], 32'h5500 + 32'(k));
    chk_reg(3'd2, 32'd0, "R6 count exhausted");
    chk_reg(3'd0, 32'h418, "R4 next address");
    wr(3'd5, 32'hA);
  endtask

  task automatic t_boundary();
    logic [31:0] s; int b;
    b = rx_idx;
    wr(3'd0, 32'hFF8); wr(3'd1, 32'h0010); wr(3'd2, 32'd1); wr(3'd3, 32'h13);
    wait_status(s);
    chk(s == 32'h8, "R8 boundary pause", s, 32'h8);
    repeat (10) @(negedge clk);
    chk(!mem_req && !rx_ready, "R8 stopped", {30'b0, mem_req, rx_ready}, 32'h0);
    chk_reg(3'd0, 32'h1000, "R8 paused address");
    chk(mem[12'h3FE] == 32'hA000_0000 + 32'(b) && mem[12'h3FF] == 32'hA000_0001 + 32'(b),
        "R8 words before boundary", mem[12'h3FF], 32'hA000_0001 + 32'(b));
    wr(3'd5, 32'h0);
    chk_reg(3'd5, 32'h8, "R11 zero write keeps");
    wr(3'd5, 32'h8);
    chk_reg(3'd5, 32'h0, "R11 one clears");
    wr(3'd0, 32'h1800);
    wait_status(s);
    chk(s == 32'h2, "R9 resumed to complete", s, 32'h2);
    chk(mem[12'h600] == 32'hA000_0002 + 32'(b) && mem[12'h601] == 32'hA000_0003 + 32'(b),
        "R9 resumed at written address", mem[12'h601], 32'hA000_0003 + 32'(b));
    chk_reg(3'd0, 32'h1808, "R9 address after resume");
    wr(3'd5, 32'hA);
  endtask

  task automatic t_code_and_coincide();
    logic [31:0] s;
    wr(3'd0, 32'hFF8); wr(3'd1, 32'h1010); wr(3'd3, 32'h11);
    wait_status(s);
    chk(s == 32'h2, "R8 8 KiB code passes 4 KiB line", s, 32'h2);
    chk_reg(3'd0, 32'h1008, "R8 address past 4 KiB");
    wr(3'd5, 32'hA);
    wr(3'd0, 32'hFF0); wr(3'd1, 32'h0010); wr(3'd3, 32'h11);
    wait_status(s);
    chk(s == 32'h2, "R10 last word on boundary", s, 32'h2);
    chk_reg(3'd0, 32'h1000, "R10 address on boundary");
    wr(3'd5, 32'hA);
  endtask

  task automatic t_zero_and_select();
    logic [31:0] s;
    mem[12'hC0] = 32'hDEAD_0001;
    wr(3'd0, 32'h300); wr(3'd1, 32'h7010); wr(3'd2, 32'd0); wr(3'd3, 32'h33);
    wait_status(s);
    chk(s == 32'h2, "R7 zero count completes", s, 32'h2);
    chk(mem[12'hC0] == 32'hDEAD_0001, "R7 nothing moved", mem[12'hC0], 32'hDEAD_0001);
    chk_reg(3'd0, 32'h300, "R7 address unchanged");
    wr(3'd5, 32'hA);
    mem[12'hD0] = 32'hDEAD_0002;
    wr(3'd4, 32'h08); wr(3'd0, 32'h340); wr(3'd3, 32'h11);
    repeat (40) @(negedge clk);
    chk_reg(3'd5, 32'h0, "R2 other select no status");
    chk(mem[12'hD0] == 32'hDEAD_0002, "R2 other select no move", mem[12'hD0], 32'hDEAD_0002);
    wr(3'd4, 32'h00);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    wr(3'd0, 32'h2000); wr(3'd1, 32'h7010); wr(3'd2, 32'd9); wr(3'd3, 32'h31);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'h5000);
    wr(3'd2, 32'd77);
    wr(3'd1, 32'h0020);
    wr(3'd3, 32'h30);
    rd(3'd0, v);
    chk(v[31:12] == 20'h2 && v != 32'h2000, "R9 write while moving ignored", v, 32'h2000);
    chk_reg(3'd2, 32'd9, "R13 count write ignored");
    chk_reg(3'd1, 32'h7010, "R13 size write ignored");
    repeat (20) @(negedge clk);
    chk_reg(3'd5, 32'h0, "R12 abort sets no status");
    chk(!mem_req && !rx_ready, "R12 engine stopped", {30'b0, mem_req, rx_ready}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_read();
    t_multi_write();
    t_boundary();
    t_code_and_coincide();
    t_zero_and_select();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule